// File: doc/BRIEF.md
# Sequenced Four-Bit ALU Datapath

This block runs one arithmetic or logic operation on two 4-bit operands for each start request. A small state machine sequences it. The function code and carry input are captured when the operation starts. Operand A is then loaded into register R0 and operand B into R1, each through a shared write bus. The ALU result is written into the result register R2 in the next cycle, and a one-cycle done pulse marks completion.

The controller's outputs are brought out as ports and are not only used inside the block. These are the operand-register clear, the write-bus source select, the ALU operation select, the per-register clock enables and the operand inversion select. ALU operations that need an inverted operand use the inversion select, so the 3-bit operation select is enough for all ten functions. Each request moves through four steps in fixed order: load A, load B, execute, done. The controller then waits in idle for the next start.

Top module: `seq_alu_unit`

## Requirements
- R1: For function codes 0 to 9, the value left in `result` is as follows. 0: A OR (NOT B). 1: A+B+carry. 2: A+(NOT B)+carry. 3: A AND B. 4: A NAND B. 5: A OR B. 6: A XOR B. 7: (NOT A) AND B. 8: A XNOR B. 9: A NOR B.
- R2: Arithmetic results are 4 bits wide. The carry out of bit 3 is discarded, so 15+15+1 gives 15 and 3+12+1 gives 0.
- R3: Function codes 10 to 15 leave `result` unchanged, and `done` still pulses at the normal time.
- R4: Take the clock edge that samples `start` high in idle as edge 0. `done` is high only in the cycle after edge 3, for exactly one cycle, and `result` holds the new value in that cycle.
- R5: While `rst` is high, after a clock edge, `done` is 0, `ce` is 0000 and `result` is 0.
- R6: A `start` that arrives while an operation is in progress, including in its done cycle, is ignored. No extra `done` pulse follows.
- R7: `func` and `carry_in` are sampled at edge 0, `opnd_a` at edge 1 and `opnd_b` at edge 2. Changes to them at other times have no effect on the result.
- R8: The control outputs follow the phase of the operation. In the load-A cycle, `ce`=0001 and `wsel`=0. In the load-B cycle, `ce`=0010 and `wsel`=1. In the execute cycle, `wsel`=2 and `ce`=0100 for a legal code or 0000 for an illegal one. In the done cycle, `clr_o`=1 and `ce`=0000.
- R9: Reset takes priority over every clock enable. Raising `rst` in the middle of an operation clears `result` at the next edge, and no `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Requests one operation |
| func | input | 4 | Function code |
| opnd_a | input | 4 | Operand A |
| opnd_b | input | 4 | Operand B |
| carry_in | input | 1 | Carry for the arithmetic functions |
| result | output | 4 | Result register R2 |
| done | output | 1 | One-cycle completion pulse |
| clr_o | output | 1 | Operand register clear |
| wsel | output | 3 | Write-bus source select (0 A, 1 B, 2 ALU) |
| fsel | output | 3 | ALU operation select |
| ce | output | 4 | Clock enables: R0, R1, R2, function latch |
| osel | output | 2 | Operand inversion select (bit1 A, bit0 B) |

## Verification
Two events can coincide here. A new start request can arrive in the same cycle that the controller is busy, including the done cycle, when completion and a fresh request overlap. The bench raises `start` during load-B and again exactly in the done cycle. It then expects no second `done` pulse over the following cycles and a `result` that has not changed. A second overlap, reset arriving in the execute cycle, is provoked by asserting `rst` there. It is judged by `result` reading zero and `done` staying low.

// File: rtl/seq_alu_unit.sv
module seq_alu_unit #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [3:0]   func,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         done,
  output logic         clr_o,
  output logic [2:0]   wsel,
  output logic [2:0]   fsel,
  output logic [3:0]   ce,
  output logic [1:0]   osel
);
  localparam logic [3:0] LAST_FN = 4'd9;

  typedef enum logic [2:0] {S_IDLE, S_LDA, S_LDB, S_EXEC, S_FIN} state_t;
  typedef enum logic [2:0] {OP_AND, OP_OR, OP_XOR, OP_ADD, OP_NAND, OP_NOR, OP_XNOR, OP_ZERO} op_t;

  state_t state, nxt;
  logic [W-1:0] r0, r1, r2, wbus, xa, xb, alu;
  logic [W:0]   sum;
  logic [3:0]   func_q;
  logic         cin_q, legal;

  assign legal = (func_q <= LAST_FN);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (start) nxt = S_LDA;
      S_LDA:   nxt = S_LDB;
      S_LDB:   nxt = S_EXEC;
      S_EXEC:  nxt = S_FIN;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk)
    if (rst) state <= S_IDLE;
    else     state <= nxt;

  always_comb begin
    ce    = 4'b0000;
    wsel  = 3'd0;
    clr_o = 1'b0;
    done  = 1'b0;
    case (state)
      S_IDLE: ce[3] = start;
      S_LDA:  begin ce[0] = 1'b1; wsel = 3'd0; end
      S_LDB:  begin ce[1] = 1'b1; wsel = 3'd1; end
      S_EXEC: begin ce[2] = legal; wsel = 3'd2; end
      S_FIN:  begin clr_o = 1'b1; done = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    fsel = OP_ZERO;
    osel = 2'b00;
    if (state == S_EXEC) begin
      case (func_q)
        4'd0: begin fsel = OP_OR;  osel = 2'b01; end
        4'd1: fsel = OP_ADD;
        4'd2: begin fsel = OP_ADD; osel = 2'b01; end
        4'd3: fsel = OP_AND;
        4'd4: fsel = OP_NAND;
        4'd5: fsel = OP_OR;
        4'd6: fsel = OP_XOR;
        4'd7: begin fsel = OP_AND; osel = 2'b10; end
        4'd8: fsel = OP_XNOR;
        4'd9: fsel = OP_NOR;
        default: ;
      endcase
    end
  end

  assign xa  = osel[1] ? ~r0 : r0;
  assign xb  = osel[0] ? ~r1 : r1;
  assign sum = {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, cin_q};

  always_comb begin
    case (op_t'(fsel))
      OP_AND:  alu = xa & xb;
      OP_OR:   alu = xa | xb;
      OP_XOR:  alu = xa ^ xb;
      OP_ADD:  alu = sum[W-1:0];
      OP_NAND: alu = ~(xa & xb);
      OP_NOR:  alu = ~(xa | xb);
      OP_XNOR: alu = ~(xa ^ xb);
      default: alu = '0;
    endcase
  end

  always_comb begin
    case (wsel)
      3'd0:    wbus = opnd_a;
      3'd1:    wbus = opnd_b;
      default: wbus = alu;
    endcase
  end

  always_ff @(posedge clk)
    if (rst || clr_o) r0 <= '0;
    else if (ce[0])   r0 <= wbus;

  always_ff @(posedge clk)
    if (rst || clr_o) r1 <= '0;
    else if (ce[1])   r1 <= wbus;

  always_ff @(posedge clk)
    if (rst)        r2 <= '0;
    else if (ce[2]) r2 <= wbus;

  always_ff @(posedge clk)
    if (rst) begin
      func_q <= '0;
      cin_q  <= 1'b0;
    end else if (ce[3]) begin
      func_q <= func;
      cin_q  <= carry_in;
    end

  assign result = r2;

  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_ce_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ce));
  a_r3_illegal_hold: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && func_q > LAST_FN) |=> $stable(result));
  a_r8_start_loads_a: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start) |=> (ce == 4'b0001 && wsel == 3'd0));
  a_r1_xor_result: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && func_q == 4'd6) |=> result == $past(r0 ^ r1));
  a_r2_add_wraps: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && func_q == 4'd1) |=> result == $past(r0 + r1 + {{(W-1){1'b0}}, cin_q}));
  a_r6_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (state == S_FIN && start) |=> ce == 4'b0000);
endmodule

// File: tb/tb_seq_alu_unit.sv
module tb_seq_alu_unit;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, carry_in = 1'b0;
  logic [3:0] func = '0, opnd_a = '0, opnd_b = '0;
  logic [3:0] result, ce;
  logic done, clr_o;
  logic [2:0] wsel, fsel;
  logic [1:0] osel;
  int checks = 0, fails = 0;
  bit timed_out = 1'b0;

  seq_alu_unit dut (.clk(clk), .rst(rst), .start(start), .func(func), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .carry_in(carry_in), .result(result), .done(done), .clr_o(clr_o),
    .wsel(wsel), .fsel(fsel), .ce(ce), .osel(osel));

  always #10 clk = ~clk;

  localparam int NV = 22;
  localparam logic [12:0] VEC [NV] = '{
    {4'd0, 4'h5, 4'h3, 1'b0}, {4'd0, 4'hA, 4'hF, 1'b1},
    {4'd1, 4'h7, 4'h8, 1'b0}, {4'd1, 4'hF, 4'hF, 1'b1},
    {4'd2, 4'h9, 4'h4, 1'b0}, {4'd2, 4'h3, 4'h3, 1'b1},
    {4'd3, 4'hC, 4'hA, 1'b0}, {4'd3, 4'h6, 4'h3, 1'b1},
    {4'd4, 4'hF, 4'h5, 1'b0}, {4'd4, 4'h2, 4'h7, 1'b1},
    {4'd5, 4'h8, 4'h1, 1'b0}, {4'd5, 4'h0, 4'h0, 1'b1},
    {4'd6, 4'hE, 4'h7, 1'b0}, {4'd6, 4'h5, 4'hA, 1'b1},
    {4'd7, 4'hC, 4'hE, 1'b0}, {4'd7, 4'h3, 4'h5, 1'b1},
    {4'd8, 4'h9, 4'h9, 1'b0}, {4'd8, 4'h6, 4'h3, 1'b1},
    {4'd9, 4'h1, 4'h2, 1'b0}, {4'd9, 4'h0, 4'h8, 1'b1},
    {4'd1, 4'h3, 4'hC, 1'b1}, {4'd2, 4'h0, 4'h1, 1'b0}
  };

  function automatic logic [3:0] model(input logic [3:0] f, a, b, input logic c);
    case (f)
      4'd0: return a | ~b;
      4'd1: return a + b + {3'b0, c};
      4'd2: return a + ~b + {3'b0, c};
      4'd3: return a & b;
      4'd4: return ~(a & b);
      4'd5: return a | b;
      4'd6: return a ^ b;
      4'd7: return ~a & b;
      4'd8: return ~(a ^ b);
      default: return ~(a | b);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one operation; scrambles inputs outside their sampling windows (R7).
  task automatic run_op(input logic [3:0] f, a, b, input logic c, output logic [3:0] res, output int dcyc);
    dcyc = -1;
    @(negedge clk);
    start = 1'b1; func = f; carry_in = c; opnd_a = a; opnd_b = ~a;
    @(negedge clk);
    start = 1'b0; func = ~f; carry_in = ~c;
    if (done) dcyc = 0;
    @(negedge clk);
    opnd_a = ~a; opnd_b = b;
    if (done && dcyc < 0) dcyc = 1;
    @(negedge clk);
    opnd_b = ~b;
    if (done && dcyc < 0) dcyc = 2;
    @(negedge clk);
    if (done && dcyc < 0) dcyc = 3;
    res = result;
    @(negedge clk);
    if (done) dcyc = 99;
  endtask

  initial begin
    #2_000_000;
    timed_out = 1'b1;
  end

  initial begin
    logic [3:0] res, exp, held;
    int dc;
    repeat (3) @(negedge clk);
    chk(result == 4'h0, "R5 result in reset", result, 0);
    chk(done == 1'b0, "R5 done in reset", done, 0);
    chk(ce == 4'b0000, "R5 ce in reset", ce, 0);
    rst = 1'b0;

    for (int i = 0; i < NV && !timed_out; i++) begin
      exp = model(VEC[i][12:9], VEC[i][8:5], VEC[i][4:1], VEC[i][0]);
      run_op(VEC[i][12:9], VEC[i][8:5], VEC[i][4:1], VEC[i][0], res, dc);
      chk(res == exp, $sformatf("R1 R2 R7 vector %0d", i), res, exp);
      chk(dc == 3, $sformatf("R4 done cycle vector %0d", i), dc, 3);
    end

    // R8: control outputs per phase
    @(negedge clk);
    start = 1'b1; func = 4'd5; opnd_a = 4'h1; opnd_b = 4'h2;
    @(negedge clk); start = 1'b0;
    chk(ce == 4'b0001 && wsel == 3'd0, "R8 load-A phase", {ce, 1'b0, wsel}, 8'h10);
    @(negedge clk);
    chk(ce == 4'b0010 && wsel == 3'd1, "R8 load-B phase", {ce, 1'b0, wsel}, 8'h21);
    @(negedge clk);
    chk(ce == 4'b0100 && wsel == 3'd2, "R8 execute phase", {ce, 1'b0, wsel}, 8'h42);
    @(negedge clk);
    chk(clr_o && ce == 4'b0000 && done, "R8 done phase", {clr_o, ce}, 5'h10);
    held = result;
    @(negedge clk);

    // R3: illegal code keeps result, done still pulses
    run_op(4'd12, 4'h9, 4'h6, 1'b1, res, dc);
    chk(res == held, "R3 illegal 12 holds result", res, held);
    chk(dc == 3, "R3 done pulses on illegal", dc, 3);
    run_op(4'd15, 4'hF, 4'hF, 1'b0, res, dc);
    chk(res == held, "R3 illegal 15 holds result", res, held);

    // R6: start during busy and in done cycle is ignored
    @(negedge clk);
    start = 1'b1; func = 4'd6; opnd_a = 4'hC; opnd_b = 4'h5; carry_in = 1'b0;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; func = 4'd3; opnd_a = 4'h0; opnd_b = 4'h0;
    @(negedge clk);
    chk(done == 1'b1, "R6 first done", done, 1);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int extra = 0;
      for (int k = 0; k < 8; k++) begin
        if (done) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R6 no extra done", extra, 0);
    end
    chk(result == 4'h9, "R6 result unchanged", result, 9);

    // R9: reset during execute
    @(negedge clk);
    start = 1'b1; func = 4'd5; opnd_a = 4'hA; opnd_b = 4'h5;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(result == 4'h0, "R9 reset clears result", result, 0);
    chk(done == 1'b0, "R9 no done under reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && ce == 4'b0000, "R5 idle after reset", {done, ce}, 0);

    if (timed_out) chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (timed_out);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule